// File: doc/BRIEF.md
# Processor Status and Interrupt Acceptance

This block holds the 16-bit processor status word and the vector base register of a 32-bit core. At each instruction boundary it decides whether a trace or an interrupt exception is taken. The core signals a boundary with a retire strobe. The block compares the trace bit and the incoming request level against the interrupt mask. When an exception is accepted, it pulses a take output and reports the vector number and the vector table address. In the same clock edge it updates the status word to the state the handler runs in.

Writes to the status word from software are checked against the privilege bit. A supervisor write replaces the whole word. A user write reaches only the condition-code byte. The condition codes also have their own update port from the execution unit. Return from exception is represented by a strobe that loads a supplied status value. The vector base register stores only its top 12 bits, so the vector table always starts on a 1 MB boundary.

Top module: `psr_exc_ctrl`

## Requirements
- R1: After reset the status word reads 0x2700 (supervisor, mask 7, trace and master clear, condition codes zero), the vector base reads 0 and exc_take is low.
- R2: A status write while the supervisor bit (bit 13) is 1 replaces the word with the written value ANDed with 0xB71F. Only bits 15 (trace), 13 (supervisor), 12 (master), 10:8 (mask) and 4:0 (X,N,Z,V,C) exist; all other bits read 0.
- R3: A status write while bit 13 is 0 changes only bits 4:0 and leaves bits 15:8 unchanged.
- R4: A condition-code update replaces bits 4:0 with ccr_upd_data when no status write, return or exception entry happens in the same cycle.
- R5: A return strobe loads rte_sr ANDed with 0xB71F, in either privilege mode.
- R6: At a retire, a request level of 1 to 6 is accepted only when it is strictly greater than the mask in bits 10:8. Acceptance gives vector 24+level and sets the supervisor bit. It clears trace and master and loads the mask with the level.
- R7: Level 7 is edge-triggered. A change of irq_level from below 7 to 7 is latched and accepted at the next retire, even with mask 7, with vector 31. Each edge gives exactly one acceptance, and a level held at 7 gives no further acceptance.
- R8: A retire with the trace bit set takes vector 9 ahead of any pending interrupt. It sets the supervisor bit and clears trace, and leaves mask and master unchanged.
- R9: A vector base write stores bits 31:20; vbr_out returns them with bits 19:0 zero.
- R10: exc_take is high for the one cycle after the accepting retire edge. exc_vector and exc_addr = vbr_out + 4*vector update at that edge and hold until the next acceptance.
- R11: In one cycle, exception entry overrides a return, which overrides a status write, which overrides a condition-code update.
- R12: mode_trace, mode_super and mode_master always equal status bits 15, 13 and 12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_level | input | 3 | Requested interrupt level, 0 = none |
| retire | input | 1 | Instruction boundary strobe |
| sr_wr_en | input | 1 | Status word write strobe |
| sr_wr_data | input | 16 | Status word write value |
| vbr_wr_en | input | 1 | Vector base write strobe |
| vbr_wr_data | input | 32 | Vector base write value |
| ccr_upd_en | input | 1 | Condition-code update strobe |
| ccr_upd_data | input | 5 | New X,N,Z,V,C bits |
| rte_en | input | 1 | Return-from-exception strobe |
| rte_sr | input | 16 | Status value restored on return |
| exc_take | output | 1 | Exception accepted pulse |
| exc_vector | output | 8 | Vector number of the last accepted exception |
| exc_addr | output | 32 | Vector table address of that exception |
| sr_out | output | 16 | Current status word |
| vbr_out | output | 32 | Current vector base |
| mode_trace | output | 1 | Trace bit |
| mode_super | output | 1 | Supervisor bit |
| mode_master | output | 1 | Master bit |

## Verification
The assertions check on every cycle that an accepted exception always lands in supervisor mode with trace clear. They also check that an interrupt vector matches the mask and clears master, and that trace vectors appear only when trace was set. Further checks cover a user write keeping the upper byte, a held level 7 never relatching, and the base register loading only its upper bits. The bench scenarios are needed for the mask comparison over many level and mask pairs, and for one acceptance per level-7 edge across a drop and rise. They also cover the order of trace before interrupt on consecutive boundaries, the override order of same-cycle writes, and the address arithmetic against a non-zero base.

// File: rtl/psr_pkg.sv
package psr_pkg;
    localparam int SR_W       = 16;
    localparam int SR_T_BIT   = 15;
    localparam int SR_S_BIT   = 13;
    localparam int SR_M_BIT   = 12;
    localparam int SR_I_LO    = 8;
    localparam int IPL_W      = 3;
    localparam int CC_W       = 5;
    localparam logic [SR_W-1:0] SR_WMASK = 16'hB71F;
    localparam logic [SR_W-1:0] SR_RESET = 16'h2700;
    localparam int TRACE_VEC  = 9;
    localparam int AUTOVEC    = 24;

    typedef enum logic [1:0] {
        EXC_NONE  = 2'd0,
        EXC_TRACE = 2'd1,
        EXC_IRQ   = 2'd2
    } exc_kind_e;
endpackage

// File: rtl/psr_lvl7_edge.sv
module psr_lvl7_edge
    import psr_pkg::*;
#(
    parameter int LVL_W = IPL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] irq_level,
    input  logic             clr,
    output logic             pend
);
    localparam logic [LVL_W-1:0] TOP = {LVL_W{1'b1}};

    typedef struct packed {
        logic [LVL_W-1:0] prev;
        logic             pend;
    } edge_st_t;

    edge_st_t st_d, st_q;
    logic     rise;

    always_comb begin
        st_d      = st_q;
        rise      = (irq_level == TOP) && (st_q.prev != TOP);
        st_d.prev = irq_level;
        st_d.pend = rise | (st_q.pend & ~clr);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend = st_q.pend;

    AST_HELD_NO_RELATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_level == TOP && st_q.prev == TOP && !st_q.pend) |=> !st_q.pend); // R7
    AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && st_q.prev == TOP) |=> !st_q.pend); // R7
endmodule

// File: rtl/psr_arbiter.sv
module psr_arbiter
    import psr_pkg::*;
#(
    parameter int LVL_W = IPL_W,
    parameter int VEC_W = 8
) (
    input  logic             retire,
    input  logic             trace_on,
    input  logic [LVL_W-1:0] mask,
    input  logic [LVL_W-1:0] irq_level,
    input  logic             top_pend,
    output logic             take,
    output exc_kind_e        kind,
    output logic [LVL_W-1:0] level,
    output logic [VEC_W-1:0] vector
);
    localparam logic [LVL_W-1:0] TOP = {LVL_W{1'b1}};

    logic lvl_ok;

    always_comb begin
        lvl_ok = (irq_level != TOP) && (irq_level > mask);
        take   = 1'b0;
        kind   = EXC_NONE;
        level  = '0;
        if (retire) begin
            if (trace_on) begin
                take = 1'b1;
                kind = EXC_TRACE;
            end else if (top_pend) begin
                take  = 1'b1;
                kind  = EXC_IRQ;
                level = TOP;
            end else if (lvl_ok) begin
                take  = 1'b1;
                kind  = EXC_IRQ;
                level = irq_level;
            end
        end
        if (kind == EXC_TRACE) begin
            vector = VEC_W'(TRACE_VEC);
        end else begin
            vector = VEC_W'(AUTOVEC) + VEC_W'(level);
        end
    end
endmodule

// File: rtl/psr_status.sv
module psr_status
    import psr_pkg::*;
#(
    parameter int LVL_W = IPL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             entry_en,
    input  exc_kind_e        entry_kind,
    input  logic [LVL_W-1:0] entry_level,
    input  logic             rte_en,
    input  logic [SR_W-1:0]  rte_sr,
    input  logic             wr_en,
    input  logic [SR_W-1:0]  wr_data,
    input  logic             cc_en,
    input  logic [CC_W-1:0]  cc_data,
    output logic [SR_W-1:0]  sr
);
    typedef struct packed {
        logic [SR_W-1:0] sr;
    } sr_st_t;

    sr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (entry_en) begin
            st_d.sr[SR_S_BIT] = 1'b1;
            st_d.sr[SR_T_BIT] = 1'b0;
            if (entry_kind == EXC_IRQ) begin
                st_d.sr[SR_M_BIT] = 1'b0;
                st_d.sr[SR_I_LO +: LVL_W] = entry_level;
            end
        end else if (rte_en) begin
            st_d.sr = rte_sr & SR_WMASK;
        end else if (wr_en) begin
            if (st_q.sr[SR_S_BIT]) begin
                st_d.sr = wr_data & SR_WMASK;
            end else begin
                st_d.sr[7:0] = wr_data[7:0] & SR_WMASK[7:0];
            end
        end else if (cc_en) begin
            st_d.sr[CC_W-1:0] = cc_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.sr <= SR_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign sr = st_q.sr;

    AST_USER_UPPER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !sr[SR_S_BIT] && !entry_en && !rte_en) |=> $stable(sr[SR_W-1:8])); // R3
    AST_CC_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (cc_en && !wr_en && !entry_en && !rte_en) |=> $stable(sr[SR_W-1:CC_W])); // R4
    AST_NO_UNUSED_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (rte_en || wr_en) |=> ((sr & ~SR_WMASK) == '0)); // R2
endmodule

// File: rtl/psr_vbr.sv
module psr_vbr #(
    parameter int ADDR_W = 32,
    parameter int KEEP   = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_data,
    output logic [ADDR_W-1:0] vbr
);
    localparam int LOW_W = ADDR_W - KEEP;

    typedef struct packed {
        logic [KEEP-1:0] base;
    } vbr_st_t;

    vbr_st_t st_d, st_q;
    logic    unused_low_bits;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.base = wr_data[ADDR_W-1:LOW_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign unused_low_bits = ^wr_data[LOW_W-1:0];
    assign vbr             = {st_q.base, {LOW_W{1'b0}}};

    AST_VBR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (vbr[ADDR_W-1:LOW_W] == $past(wr_data[ADDR_W-1:LOW_W]))); // R9
endmodule

// File: rtl/psr_exc_ctrl.sv
module psr_exc_ctrl
    import psr_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int VBR_KEEP = 12,
    parameter int VEC_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        irq_level,
    input  logic              retire,
    input  logic              sr_wr_en,
    input  logic [15:0]       sr_wr_data,
    input  logic              vbr_wr_en,
    input  logic [ADDR_W-1:0] vbr_wr_data,
    input  logic              ccr_upd_en,
    input  logic [4:0]        ccr_upd_data,
    input  logic              rte_en,
    input  logic [15:0]       rte_sr,
    output logic              exc_take,
    output logic [VEC_W-1:0]  exc_vector,
    output logic [ADDR_W-1:0] exc_addr,
    output logic [15:0]       sr_out,
    output logic [ADDR_W-1:0] vbr_out,
    output logic              mode_trace,
    output logic              mode_super,
    output logic              mode_master
);
    localparam int SHIFT = 2;

    typedef struct packed {
        logic              take;
        logic [VEC_W-1:0]  vector;
        logic [ADDR_W-1:0] addr;
    } out_st_t;

    out_st_t          st_d, st_q;
    logic             arb_take;
    exc_kind_e        arb_kind;
    logic [IPL_W-1:0] arb_level;
    logic [VEC_W-1:0] arb_vector;
    logic             top_pend;
    logic [SR_W-1:0]  sr_q;
    logic [ADDR_W-1:0] vbr_q;

    psr_lvl7_edge #(.LVL_W(IPL_W)) u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_level (irq_level),
        .clr       (arb_take && arb_kind == EXC_IRQ && arb_level == {IPL_W{1'b1}}),
        .pend      (top_pend)
    );

    psr_arbiter #(.LVL_W(IPL_W), .VEC_W(VEC_W)) u_arb (
        .retire    (retire),
        .trace_on  (sr_q[SR_T_BIT]),
        .mask      (sr_q[SR_I_LO +: IPL_W]),
        .irq_level (irq_level),
        .top_pend  (top_pend),
        .take      (arb_take),
        .kind      (arb_kind),
        .level     (arb_level),
        .vector    (arb_vector)
    );

    psr_status #(.LVL_W(IPL_W)) u_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .entry_en    (arb_take),
        .entry_kind  (arb_kind),
        .entry_level (arb_level),
        .rte_en      (rte_en),
        .rte_sr      (rte_sr),
        .wr_en       (sr_wr_en),
        .wr_data     (sr_wr_data),
        .cc_en       (ccr_upd_en),
        .cc_data     (ccr_upd_data),
        .sr          (sr_q)
    );

    psr_vbr #(.ADDR_W(ADDR_W), .KEEP(VBR_KEEP)) u_vbr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (vbr_wr_en),
        .wr_data (vbr_wr_data),
        .vbr     (vbr_q)
    );

    always_comb begin
        st_d      = st_q;
        st_d.take = arb_take;
        if (arb_take) begin
            st_d.vector = arb_vector;
            st_d.addr   = vbr_q + (ADDR_W'(arb_vector) << SHIFT);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign exc_take    = st_q.take;
    assign exc_vector  = st_q.vector;
    assign exc_addr    = st_q.addr;
    assign sr_out      = sr_q;
    assign vbr_out     = vbr_q;
    assign mode_trace  = sr_q[SR_T_BIT];
    assign mode_super  = sr_q[SR_S_BIT];
    assign mode_master = sr_q[SR_M_BIT];

    AST_TAKE_SUPER: assert property (@(posedge clk) disable iff (!rst_n)
        exc_take |-> (sr_out[SR_S_BIT] && !sr_out[SR_T_BIT])); // R6
    AST_IRQ_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_take && exc_vector != VEC_W'(TRACE_VEC)) |->
            (sr_out[SR_I_LO +: IPL_W] == IPL_W'(exc_vector - VEC_W'(AUTOVEC)) && !sr_out[SR_M_BIT])); // R6
    AST_TRACE_NEEDS_T: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_take && exc_vector == VEC_W'(TRACE_VEC)) |-> $past(mode_trace)); // R8
    AST_ADDR_FROM_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_take && $past(!vbr_wr_en)) |->
            (exc_addr == vbr_out + (ADDR_W'(exc_vector) << SHIFT))); // R10
endmodule

// File: tb/test_psr_exc_ctrl.sv
module test_psr_exc_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  irq_level = '0;
    logic        retire = 1'b0;
    logic        sr_wr_en = 1'b0;
    logic [15:0] sr_wr_data = '0;
    logic        vbr_wr_en = 1'b0;
    logic [31:0] vbr_wr_data = '0;
    logic        ccr_upd_en = 1'b0;
    logic [4:0]  ccr_upd_data = '0;
    logic        rte_en = 1'b0;
    logic [15:0] rte_sr = '0;
    logic        exc_take;
    logic [7:0]  exc_vector;
    logic [31:0] exc_addr;
    logic [15:0] sr_out;
    logic [31:0] vbr_out;
    logic        mode_trace, mode_super, mode_master;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    psr_exc_ctrl i_psr_exc_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_level(irq_level), .retire(retire),
        .sr_wr_en(sr_wr_en), .sr_wr_data(sr_wr_data),
        .vbr_wr_en(vbr_wr_en), .vbr_wr_data(vbr_wr_data),
        .ccr_upd_en(ccr_upd_en), .ccr_upd_data(ccr_upd_data),
        .rte_en(rte_en), .rte_sr(rte_sr),
        .exc_take(exc_take), .exc_vector(exc_vector), .exc_addr(exc_addr),
        .sr_out(sr_out), .vbr_out(vbr_out),
        .mode_trace(mode_trace), .mode_super(mode_super), .mode_master(mode_master)
    );

    // {mask[14:12], level[11:9], take[8], vector[7:0]}
    localparam logic [14:0] TBL [8] = '{
        {3'd0, 3'd1, 1'b1, 8'd25},
        {3'd3, 3'd3, 1'b0, 8'd0},
        {3'd3, 3'd4, 1'b1, 8'd28},
        {3'd6, 3'd6, 1'b0, 8'd0},
        {3'd5, 3'd6, 1'b1, 8'd30},
        {3'd2, 3'd1, 1'b0, 8'd0},
        {3'd0, 3'd0, 1'b0, 8'd0},
        {3'd1, 3'd2, 1'b1, 8'd26}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cycle();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic sr_write(input logic [15:0] v);
        sr_wr_en = 1'b1; sr_wr_data = v;
        cycle();
        sr_wr_en = 1'b0;
    endtask

    task automatic do_retire();
        retire = 1'b1;
        cycle();
        retire = 1'b0;
    endtask

    initial begin
        repeat (3) cycle();
        rst_n = 1'b1;
        cycle();
        check("R1 sr", 32'(sr_out), 32'h2700);
        check("R1 vbr", vbr_out, 32'h0);
        check("R1 take", 32'(exc_take), 32'h0);

        // table of mask/level pairs
        for (int i = 0; i < 8; i++) begin
            irq_level = 3'd0;
            sr_write(16'h2000 | (16'(TBL[i][14:12]) << 8));
            irq_level = TBL[i][11:9];
            do_retire();
            check($sformatf("R6 take row%0d", i), 32'(exc_take), 32'(TBL[i][8]));
            if (TBL[i][8]) begin
                check($sformatf("R6 vector row%0d", i), 32'(exc_vector), 32'(TBL[i][7:0]));
                check($sformatf("R6 sr row%0d", i), 32'(sr_out),
                      32'(16'h2000 | (16'(TBL[i][11:9]) << 8)));
            end
        end
        irq_level = 3'd0;

        // R2 and R12: supervisor write sets trace/master, clears supervisor
        sr_write(16'hFFFF & 16'h9000);
        check("R2 sr", 32'(sr_out), 32'h9000);
        check("R12 modes", {29'd0, mode_trace, mode_super, mode_master}, 32'b101);
        sr_write(16'h8000);
        sr_wr_en = 1'b0;
        // back to supervisor via rte to allow full write
        rte_en = 1'b1; rte_sr = 16'hFFFF; cycle(); rte_en = 1'b0;
        check("R5 rte mask", 32'(sr_out), 32'hB71F);
        sr_write(16'h9000);

        // R8: trace ahead of pending level 5, then the interrupt
        irq_level = 3'd5;
        do_retire();
        check("R8 take", 32'(exc_take), 32'h1);
        check("R8 vector", 32'(exc_vector), 32'd9);
        check("R8 sr", 32'(sr_out), 32'h3000);
        check("R10 trace addr", exc_addr, 32'h24);
        do_retire();
        check("R6 after trace vector", 32'(exc_vector), 32'd29);
        check("R6 after trace sr", 32'(sr_out), 32'h2500);
        irq_level = 3'd0;

        // R11: exception entry beats a same-cycle status write
        sr_write(16'h8000);
        sr_wr_en = 1'b1; sr_wr_data = 16'h0017; retire = 1'b1;
        cycle();
        sr_wr_en = 1'b0; retire = 1'b0;
        check("R11 entry wins", 32'(sr_out), 32'h2000);
        // status write beats condition-code update
        sr_wr_en = 1'b1; sr_wr_data = 16'h2100; ccr_upd_en = 1'b1; ccr_upd_data = 5'h1F;
        cycle();
        sr_wr_en = 1'b0; ccr_upd_en = 1'b0;
        check("R11 write wins", 32'(sr_out), 32'h2100);
        // return beats status write
        rte_en = 1'b1; rte_sr = 16'h2400; sr_wr_en = 1'b1; sr_wr_data = 16'h2600;
        cycle();
        rte_en = 1'b0; sr_wr_en = 1'b0;
        check("R11 rte wins", 32'(sr_out), 32'h2400);

        // R7: level-7 edge with mask 7
        sr_write(16'h2700);
        irq_level = 3'd7;
        cycle();
        do_retire();
        check("R7 take", 32'(exc_take), 32'h1);
        check("R7 vector", 32'(exc_vector), 32'd31);
        check("R7 mask", 32'(sr_out), 32'h2700);
        do_retire();
        check("R7 held no repeat", 32'(exc_take), 32'h0);
        irq_level = 3'd3; cycle();
        irq_level = 3'd7; cycle();
        do_retire();
        check("R7 second edge", 32'(exc_take), 32'h1);
        irq_level = 3'd0;

        // R9 / R10
        vbr_wr_en = 1'b1; vbr_wr_data = 32'h12345678;
        cycle();
        vbr_wr_en = 1'b0;
        check("R9 vbr", vbr_out, 32'h12300000);
        sr_write(16'h2000);
        irq_level = 3'd4;
        do_retire();
        check("R10 addr", exc_addr, 32'h12300070);
        irq_level = 3'd0;
        cycle();
        check("R10 pulse ends", 32'(exc_take), 32'h0);
        check("R10 vector held", 32'(exc_vector), 32'd28);

        // R3 / R5 / R4 in user mode
        sr_write(16'h0000);
        sr_write(16'hFFFF);
        check("R3 user write", 32'(sr_out), 32'h001F);
        rte_en = 1'b1; rte_sr = 16'h2300; cycle(); rte_en = 1'b0;
        check("R5 rte", 32'(sr_out), 32'h2300);
        ccr_upd_en = 1'b1; ccr_upd_data = 5'h15; cycle(); ccr_upd_en = 1'b0;
        check("R4 ccr", 32'(sr_out), 32'h2315);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule